// File: doc/BRIEF.md
# Shared-Bus Converter Control and Result Port

This block is the digital front end of a 12-bit data converter whose control path and result path share one 8-bit bus. A host selects the device with an active-low chip-select. Under that select, a write strobe loads a control byte, and a read strobe drives one byte of the most recent conversion result back onto the bus. Because the bus is tri-state, the block produces a drive enable next to its data output, and it gives the bus back whenever it is not being read.

The control byte sets three things: the conversion clock source (internal or external), a power-down request, and the number format (unipolar or bipolar). The block keeps track of the clock source. A power-down request does not change it. When external clocking is active, the block passes the external conversion clock pin through to the core. A stub outside the block supplies results through a valid/data port. A byte-select input picks which half of the result a read returns: the low eight bits, or the top four bits padded to a full byte according to the number format.

The write strobe is sampled in the system clock domain by a two-state strobe machine, WS_IDLE and WS_LOW. WS_IDLE moves to WS_LOW when chip-select and write are both low. WS_LOW moves back to WS_IDLE in two cases. If write rises while chip-select is still low, the byte is committed. If chip-select rises first, the write is aborted. The mode machine has four states: MS_EXT, MS_INT, MS_PD_EXT and MS_PD_INT. A clock-select code moves it to MS_EXT or MS_INT. A power-down code moves MS_EXT or MS_PD_EXT to MS_PD_EXT, and MS_INT or MS_PD_INT to MS_PD_INT.

Top module: `pbus_cvt_front`

## Requirements
- R1: After reset, `int_mode` is 0 (external clock), `pwr_down` is 0, the format is unipolar, the stored result is zero and `bus_oe` is 0.
- R2: A committed control byte with bits 7..6 = 2'b10 sets `int_mode` to 1, visible from the first clock edge after the one at which `wr_n` is sampled high again.
- R3: A committed control byte with bits 7..6 = 2'b11 sets `int_mode` to 0, with the same timing as R2.
- R4: A committed control byte with bits 7..6 = 2'b00 or 2'b01 sets `pwr_down` to 1 and leaves `int_mode` unchanged.
- R5: `pwr_down` returns to 0 on the next committed byte that carries a clock-select code (2'b10 or 2'b11).
- R6: While `cs_n` is high, write strobes have no effect. If `cs_n` rises while a write strobe is low, that write is discarded.
- R7: `bus_oe` is 1 exactly while `cs_n` and `rd_n` are both low. Whenever `bus_oe` is 0, `bus_out` is 8'h00.
- R8: With `hsel` = 0, a read returns bits 7..0 of the stored result.
- R9: With `hsel` = 1 in unipolar format, a read returns {4'b0000, result[11:8]}.
- R10: Bit 3 of each committed control byte sets the format (1 = bipolar, two's complement). With `hsel` = 1 in bipolar format, a read returns {4{result[11]}, result[11:8]}.
- R11: `cnv_clk_out` follows `cnv_clk_in` while `cs_n` is low and `int_mode` is 0, and is 0 otherwise.
- R12: A cycle with `res_valid` = 1 stores `res_data`, and reads from the next cycle onward return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip-select |
| wr_n | input | 1 | Active-low write strobe, sampled on clk |
| rd_n | input | 1 | Active-low read strobe |
| hsel | input | 1 | Byte select for reads: 0 = low byte, 1 = high byte |
| bus_in | input | 8 | Bus value seen by the block (control byte) |
| bus_out | output | 8 | Value the block drives onto the bus |
| bus_oe | output | 1 | Bus drive enable; the bus is high impedance when 0 |
| res_valid | input | 1 | Strobe marking a new conversion result |
| res_data | input | 12 | Conversion result from the core stub |
| cnv_clk_in | input | 1 | External conversion clock pin |
| cnv_clk_out | output | 1 | Gated conversion clock to the core |
| int_mode | output | 1 | 1 = internal clock mode active |
| pwr_down | output | 1 | 1 = a power-down request is in force |

## Verification
The bench targets power-down retention from both clock modes. A design that decodes the mode field naively would fall back to external mode, or take the power-down byte as a mode change. The bench aborts a write by raising chip-select mid-strobe and also strobes while deselected. A design that commits the byte on the write edge alone would change mode in those cases. High-byte reads use results with the MSB set and clear, in both formats. This catches padding taken from the wrong bit, or padding applied in unipolar format. It also checks that the format bit is reloaded by every committed byte, including power-down bytes.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [1:0] {
        MS_EXT    = 2'd0,
        MS_INT    = 2'd1,
        MS_PD_EXT = 2'd2,
        MS_PD_INT = 2'd3
    } mode_st_t;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_LOW  = 1'b1
    } wr_st_t;

    localparam logic [1:0] SEL_CODE_INT = 2'b10;
    localparam logic [1:0] SEL_CODE_EXT = 2'b11;

endpackage

// File: rtl/pbus_wr_ctrl.sv
module pbus_wr_ctrl
    import pbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic [DW-1:0] bus_in,
    output logic          ctl_fire,
    output logic [DW-1:0] ctl_byte
);

    wr_st_t        st_q;
    wr_st_t        st_d;
    logic [DW-1:0] hold_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WS_IDLE;
        else        st_q <= st_d;
    end

    // capture the bus every cycle the strobe is low under select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               hold_q <= '0;
        else if (!cs_n && !wr_n)  hold_q <= bus_in;
    end

    // next state and commit pulse
    always_comb begin
        st_d     = st_q;
        ctl_fire = 1'b0;
        unique case (st_q)
            WS_IDLE: begin
                if (!cs_n && !wr_n) st_d = WS_LOW;
            end
            WS_LOW: begin
                if (cs_n) begin
                    st_d = WS_IDLE;
                end else if (wr_n) begin
                    st_d     = WS_IDLE;
                    ctl_fire = 1'b1;
                end
            end
            default: st_d = WS_IDLE;
        endcase
    end

    assign ctl_byte = hold_q;

    // a commit always follows a cycle with the strobe low (R2)
    p_fire_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_fire |-> $past(!wr_n && !cs_n));

endmodule

// File: rtl/pbus_mode_fsm.sv
module pbus_mode_fsm
    import pbus_pkg::*;
#(
    parameter int DW      = 8,
    parameter int SEL_HI  = 7,
    parameter int BIP_BIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_fire,
    input  logic [DW-1:0] ctl_byte,
    output logic          int_mode,
    output logic          pwr_down,
    output logic          bipolar
);

    localparam int SEL_LO = SEL_HI - 1;

    mode_st_t   st_q;
    mode_st_t   st_d;
    logic       bip_q;
    logic [1:0] code;

    assign code = ctl_byte[SEL_HI:SEL_LO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MS_EXT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bip_q <= 1'b0;
        else if (ctl_fire) bip_q <= ctl_byte[BIP_BIT];
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (ctl_fire) begin
            if (code == SEL_CODE_EXT) begin
                st_d = MS_EXT;
            end else if (code == SEL_CODE_INT) begin
                st_d = MS_INT;
            end else begin
                unique case (st_q)
                    MS_EXT, MS_PD_EXT: st_d = MS_PD_EXT;
                    MS_INT, MS_PD_INT: st_d = MS_PD_INT;
                    default:           st_d = MS_PD_EXT;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            MS_EXT:    begin int_mode = 1'b0; pwr_down = 1'b0; end
            MS_INT:    begin int_mode = 1'b1; pwr_down = 1'b0; end
            MS_PD_EXT: begin int_mode = 1'b0; pwr_down = 1'b1; end
            MS_PD_INT: begin int_mode = 1'b1; pwr_down = 1'b1; end
            default:   begin int_mode = 1'b0; pwr_down = 1'b0; end
        endcase
    end

    assign bipolar = bip_q;

    p_int_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_fire && code == SEL_CODE_INT) |=> (int_mode && !pwr_down));

    p_ext_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_fire && code == SEL_CODE_EXT) |=> (!int_mode && !pwr_down));

    p_pd_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_fire && !code[1]) |=> (pwr_down && int_mode == $past(int_mode)));

endmodule

// File: rtl/pbus_rd_fmt.sv
module pbus_rd_fmt #(
    parameter int DW = 8,
    parameter int RW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_valid,
    input  logic [RW-1:0] res_data,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          hsel,
    input  logic          bipolar,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe
);

    localparam int HI_W = RW - DW;

    logic [RW-1:0] res_q;
    logic [DW-1:0] hi_byte;
    logic [DW-1:0] sel_byte;
    logic          pad_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         res_q <= '0;
        else if (res_valid) res_q <= res_data;
    end

    assign pad_bit = bipolar & res_q[RW-1];

    generate
        for (genvar g = 0; g < DW; g++) begin : g_hi
            if (g < HI_W) begin : g_val
                assign hi_byte[g] = res_q[DW+g];
            end else begin : g_pad
                assign hi_byte[g] = pad_bit;
            end
        end
    endgenerate

    assign sel_byte = hsel ? hi_byte : res_q[DW-1:0];
    assign bus_oe   = !cs_n && !rd_n;
    assign bus_out  = bus_oe ? sel_byte : '0;

    always_comb begin
        if (rst_n && bus_oe && hsel && !bipolar)
            a_pad_zero_r9: assert (bus_out[DW-1:HI_W] == '0);
        if (rst_n && bus_oe && hsel && bipolar)
            a_pad_sign_r10: assert (bus_out[DW-1:HI_W] == {(DW-HI_W){bus_out[HI_W-1]}});
        if (!bus_oe)
            a_quiet_r7: assert (bus_out == '0);
    end

endmodule

// File: rtl/pbus_cvt_front.sv
module pbus_cvt_front
    import pbus_pkg::*;
#(
    parameter int DW      = 8,
    parameter int RW      = 12,
    parameter int SEL_HI  = 7,
    parameter int BIP_BIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          hsel,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    input  logic          res_valid,
    input  logic [RW-1:0] res_data,
    input  logic          cnv_clk_in,
    output logic          cnv_clk_out,
    output logic          int_mode,
    output logic          pwr_down
);

    logic          ctl_fire;
    logic [DW-1:0] ctl_byte;
    logic          bipolar;

    pbus_wr_ctrl #(.DW(DW)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .bus_in   (bus_in),
        .ctl_fire (ctl_fire),
        .ctl_byte (ctl_byte)
    );

    pbus_mode_fsm #(.DW(DW), .SEL_HI(SEL_HI), .BIP_BIT(BIP_BIT)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_fire (ctl_fire),
        .ctl_byte (ctl_byte),
        .int_mode (int_mode),
        .pwr_down (pwr_down),
        .bipolar  (bipolar)
    );

    pbus_rd_fmt #(.DW(DW), .RW(RW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .hsel      (hsel),
        .bipolar   (bipolar),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe)
    );

    assign cnv_clk_out = cnv_clk_in && !cs_n && !int_mode;

    // deselected cycles never alter the mode state (R6)
    p_cs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(int_mode) && $stable(pwr_down)));

    // a clock-select commit clears power-down (R5)
    p_pd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_fire && ctl_byte[SEL_HI]) |=> !pwr_down);

endmodule

// File: tb/pbus_cvt_front_bench.sv
`timescale 1ns/1ps
module pbus_cvt_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, hsel = 1'b0;
    logic [7:0]  bus_in = 8'h00;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = 12'h000;
    logic        cnv_clk_in = 1'b0;
    logic        cnv_clk_out, int_mode, pwr_down;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_int = 0, m_pd = 0, m_bip = 0, m_res = 0, m_wrlow = 0, m_hold = 0;

    always #2 clk = ~clk;

    pbus_cvt_front u_pbus_cvt_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .hsel(hsel), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .res_valid(res_valid), .res_data(res_data), .cnv_clk_in(cnv_clk_in),
        .cnv_clk_out(cnv_clk_out), .int_mode(int_mode), .pwr_down(pwr_down)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_int = 0; m_pd = 0; m_bip = 0; m_res = 0; m_wrlow = 0; m_hold = 0;
        end else begin
            if (res_valid) m_res = int'(res_data);
            if (cs_n) begin
                m_wrlow = 0;
            end else if (!wr_n) begin
                m_wrlow = 1;
                m_hold  = int'(bus_in);
            end else if (m_wrlow == 1) begin
                m_wrlow = 0;
                if (m_hold >= 128) begin
                    m_int = ((m_hold / 64) % 2 == 1) ? 0 : 1;
                    m_pd  = 0;
                end else begin
                    m_pd = 1;
                end
                m_bip = (m_hold / 8) % 2;
            end
        end
    endtask

    task automatic compare();
        int exp_oe, exp_out, hi, pad;
        exp_oe = (!cs_n && !rd_n) ? 1 : 0;
        hi     = (m_res / 256) % 16;
        pad    = (m_bip == 1 && hi >= 8) ? 240 : 0;
        if (exp_oe == 0)   exp_out = 0;
        else if (hsel)     exp_out = pad + hi;
        else               exp_out = m_res % 256;
        chk("int_mode", int'(int_mode), m_int);
        chk("pwr_down", int'(pwr_down), m_pd);
        chk("bus_oe", int'(bus_oe), exp_oe);
        chk("bus_out", int'(bus_out), exp_out);
        chk("cnv_clk_out", int'(cnv_clk_out),
            (cnv_clk_in && !cs_n && m_int == 0) ? 1 : 0);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cycles++;
        compare();
        res_valid  = 1'b0;
        cnv_clk_in = ~cnv_clk_in;
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic sel_n);
        cs_n = sel_n; wr_n = 1'b0; bus_in = b; tick();
        wr_n = 1'b1; tick();
        cs_n = 1'b1; tick();
    endtask

    task automatic rd_byte(input logic hs);
        cs_n = 1'b0; rd_n = 1'b0; hsel = hs; tick();
        rd_n = 1'b1; cs_n = 1'b1; tick();
    endtask

    task automatic load_res(input logic [11:0] v);
        res_valid = 1'b1; res_data = v; tick();
    endtask

    initial begin
        #50000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        cur_req = "R1";
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) tick();
        rd_byte(1'b1);

        cur_req = "R12"; load_res(12'hA5C);
        cur_req = "R8";  rd_byte(1'b0);
        cur_req = "R9";  rd_byte(1'b1);

        cur_req = "R4";  wr_byte(8'h08, 1'b0);
        cur_req = "R10"; rd_byte(1'b1);
        cur_req = "R2";  wr_byte(8'h80, 1'b0);
        cur_req = "R5";  tick();
        cur_req = "R4";  wr_byte(8'h40, 1'b0);
        cur_req = "R9";  rd_byte(1'b1);
        cur_req = "R3";  wr_byte(8'hC0, 1'b0);

        cur_req = "R6";
        wr_byte(8'h80, 1'b1);
        rd_byte(1'b0);
        cs_n = 1'b0; wr_n = 1'b0; bus_in = 8'h80; tick();
        cs_n = 1'b1; tick();
        wr_n = 1'b1; tick();

        cur_req = "R7";
        cs_n = 1'b0; rd_n = 1'b1; tick();
        rd_n = 1'b0; tick();
        cs_n = 1'b1; tick();
        rd_n = 1'b1; tick();

        cur_req = "R12"; load_res(12'h3F1);
        cur_req = "R10"; wr_byte(8'hC8, 1'b0);
        rd_byte(1'b1);
        load_res(12'h8F7);
        rd_byte(1'b1);

        cur_req = "R11";
        cs_n = 1'b0;
        for (int i = 0; i < 4; i++) tick();
        cs_n = 1'b1;
        for (int i = 0; i < 2; i++) tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule